// File: doc/BRIEF.md
# Sixteen-Operation Bit-Sliced Arithmetic Logic Unit

This block is a 32-bit arithmetic logic unit with sixteen fixed operations. Two operands and a 4-bit operation code come in. One clock edge later a registered result and a registered carry/borrow flag come out. The datapath is a row of identical one-bit slices, and the carry ripples from the least significant slice to the most significant one.

Each slice is built from behavioural models of reversible primitives:
- a two-output exclusive-or/and cell, which gives AND and XOR from one cell;
- a three-input controlled-AND cell, which gates the second operand;
- a controlled-swap cell, used as a 2:1 multiplexer;
- a dual-mode cell that acts as a full adder or as a full subtractor.

The top bit of the operation code picks the logic half or the arithmetic half of every slice. A small decoder turns the code into per-slice controls. These controls choose the first arithmetic operand (A, ~A, constant one or constant zero), gate B, set the chain's initial carry and choose add or subtract mode. As a result, set, clear, NOT, increment, decrement and two's complement all travel the same ripple chain as add and subtract.

Top module: `alu16_top`

## Requirements
- R1: A synchronous active-high reset clears `result` and `cout` to zero. Otherwise both outputs show, one clock after the edge that samples them, the values computed from `op`, `a` and `b`.
- R2: For every code with `op[3]` = 0 (codes 0 to 7), `cout` is 0.
- R3: Code 0 gives A AND B, code 1 gives NOT(A AND B), code 2 gives A OR B, code 3 gives NOT(A OR B).
- R4: Code 4 gives A, code 5 gives A XOR B, code 6 gives B, code 7 gives NOT(A XOR B).
- R5: Code 8 gives A + B modulo 2^32. `cout` is the carry out of bit 31.
- R6: Code 9 gives A + 1, with `cout` = 1 exactly when A is all ones. Code 10 gives (~A) + 1, with `cout` = 1 exactly when A is zero. The carry must travel through all 32 slices.
- R7: Code 11 gives all ones, code 15 gives all zeros and code 14 gives ~A. For all three, `cout` is 0.
- R8: Code 12 gives A − B modulo 2^32, with `cout` = 1 (borrow) exactly when A < B as unsigned numbers.
- R9: Code 13 gives A − 1, with `cout` = 1 (borrow) exactly when A is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code, 0 to 15 |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Registered result |
| cout | output | 1 | Registered carry (codes 8 to 10) or borrow (codes 12 and 13); 0 otherwise |

## Verification
A wrong control bit from the decoder, or a miswired slice, shows up in the very next registered result for the affected code. Stuck carry links only show when a carry or borrow must cross them. For that reason the stimulus includes all-ones, zero and the lone top bit, which push a carry through every slice in one cycle. A fault in the final carry gating shows as a nonzero `cout` on a logic, set, clear or NOT code one cycle later.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,  OP_NAND = 4'd1,  OP_OR   = 4'd2,  OP_NOR  = 4'd3,
    OP_PASA = 4'd4,  OP_XOR  = 4'd5,  OP_PASB = 4'd6,  OP_XNOR = 4'd7,
    OP_ADD  = 4'd8,  OP_INC  = 4'd9,  OP_NEG  = 4'd10, OP_SET  = 4'd11,
    OP_SUB  = 4'd12, OP_DEC  = 4'd13, OP_NOT  = 4'd14, OP_CLR  = 4'd15
  } op_e;

  // logic pick: 0 and, 1 or, 2 pass a, 3 xor, 4 pass b
  typedef struct packed {
    logic       arith;   // 1: arithmetic half drives the output
    logic [2:0] lpick;
    logic       linv;
    logic [1:0] xsel;    // 00 a, 01 ~a, 10 one, 11 zero
    logic       use_b;
    logic       sub;
    logic       cin;
  } slice_ctl_t;

endpackage

// File: rtl/alu16_gates.sv
// Behavioural reversible primitives; pass-through (garbage) outputs omitted.

// Peres-style cell: q = a ^ b, r = (a & b) ^ c
module rev_peres (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic q,
  output logic r
);
  assign q = a ^ b;
  assign r = (a & b) ^ c;
endmodule

// Toffoli cell: r = (a & b) ^ c
module rev_toffoli (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic r
);
  assign r = (a & b) ^ c;
endmodule

// Controlled swap used as 2:1 mux: q = sel ? d1 : d0
module rev_cswap (
  input  logic sel,
  input  logic d0,
  input  logic d1,
  output logic q
);
  assign q = (~sel & d0) | (sel & d1);
endmodule

// Dual-mode cell: full adder when sub = 0, full subtractor when sub = 1
module rev_addsub (
  input  logic sub,
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic xe;
  assign xe = x ^ sub;
  assign s  = x ^ y ^ ci;
  assign co = (xe & y) | (xe & ci) | (y & ci);
endmodule

// File: rtl/alu16_slice.sv
module alu16_slice
  import alu16_pkg::*;
(
  input  slice_ctl_t ctl,
  input  logic       a,
  input  logic       b,
  input  logic       ci,
  output logic       r,
  output logic       co
);
  // logic half
  logic x_ab, and_ab, or_ab;
  logic m_ao, m_ax, m_lo, m_lb, lbit;

  rev_peres u_peres (.a(a), .b(b), .c(1'b0), .q(x_ab), .r(and_ab));
  assign or_ab = and_ab ^ x_ab;

  rev_cswap u_m0 (.sel(ctl.lpick[0]), .d0(and_ab), .d1(or_ab), .q(m_ao));
  rev_cswap u_m1 (.sel(ctl.lpick[0]), .d0(a),      .d1(x_ab),  .q(m_ax));
  rev_cswap u_m2 (.sel(ctl.lpick[1]), .d0(m_ao),   .d1(m_ax),  .q(m_lo));
  rev_cswap u_m3 (.sel(ctl.lpick[2]), .d0(m_lo),   .d1(b),     .q(m_lb));
  assign lbit = m_lb ^ ctl.linv;

  // arithmetic half
  logic xa, xk, xo, yg, dbit;
  rev_cswap u_xa (.sel(ctl.xsel[0]), .d0(a),    .d1(~a),   .q(xa));
  rev_cswap u_xk (.sel(ctl.xsel[0]), .d0(1'b1), .d1(1'b0), .q(xk));
  rev_cswap u_xo (.sel(ctl.xsel[1]), .d0(xa),   .d1(xk),   .q(xo));
  rev_toffoli u_yg (.a(b), .b(ctl.use_b), .c(1'b0), .r(yg));
  rev_addsub  u_as (.sub(ctl.sub), .x(xo), .y(yg), .ci(ci), .s(dbit), .co(co));

  rev_cswap u_out (.sel(ctl.arith), .d0(lbit), .d1(dbit), .q(r));
endmodule

// File: rtl/alu16_top.sv
module alu16_top
  import alu16_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         cout
);
  localparam int CW = W + 1;

  slice_ctl_t    ctl;
  logic [CW-1:0] chain;
  logic [W-1:0]  res_d;

  always_comb begin
    ctl       = '0;
    ctl.arith = op[3];
    ctl.xsel  = 2'b11;
    unique case (op_e'(op))
      OP_AND:  begin ctl.lpick = 3'd0; end
      OP_NAND: begin ctl.lpick = 3'd0; ctl.linv = 1'b1; end
      OP_OR:   begin ctl.lpick = 3'd1; end
      OP_NOR:  begin ctl.lpick = 3'd1; ctl.linv = 1'b1; end
      OP_PASA: begin ctl.lpick = 3'd2; end
      OP_XOR:  begin ctl.lpick = 3'd3; end
      OP_PASB: begin ctl.lpick = 3'd4; end
      OP_XNOR: begin ctl.lpick = 3'd3; ctl.linv = 1'b1; end
      OP_ADD:  begin ctl.xsel = 2'b00; ctl.use_b = 1'b1; end
      OP_INC:  begin ctl.xsel = 2'b00; ctl.cin = 1'b1; end
      OP_NEG:  begin ctl.xsel = 2'b01; ctl.cin = 1'b1; end
      OP_SET:  begin ctl.xsel = 2'b10; end
      OP_SUB:  begin ctl.xsel = 2'b00; ctl.use_b = 1'b1; ctl.sub = 1'b1; end
      OP_DEC:  begin ctl.xsel = 2'b00; ctl.cin = 1'b1; ctl.sub = 1'b1; end
      OP_NOT:  begin ctl.xsel = 2'b01; end
      OP_CLR:  begin ctl.xsel = 2'b11; end
      default: begin ctl.xsel = 2'b11; end
    endcase
  end

  assign chain[0] = ctl.cin;

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu16_slice u_slice (
      .ctl (ctl),
      .a   (a[i]),
      .b   (b[i]),
      .ci  (chain[i]),
      .r   (res_d[i]),
      .co  (chain[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      cout   <= 1'b0;
    end else begin
      result <= res_d;
      cout   <= op[3] & chain[W];
    end
  end
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] result,
  input logic         cout
);
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && cout == 1'b0));

  p_logic_nocarry_r2: assert property (@(posedge clk) disable iff (rst)
    (op[3] == 1'b0) |=> (cout == 1'b0));

  p_pass_b_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd6) |=> (result == $past(b)));

  p_set_ones_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd11) |=> (result == '1 && !cout));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd15) |=> (result == '0 && !cout));

  p_not_a_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd14) |=> (result == ~$past(a)));

  p_dec_borrow_r9: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd13 && a == '0) |=> (cout && result == '1));
endmodule

bind alu16_top alu16_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .result(result), .cout(cout)
);

// File: tb/test_alu16_top.sv
`timescale 1ns/1ps
module test_alu16_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op  = '0;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [W-1:0] result;
  logic         cout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  alu16_top #(.W(W)) i_alu16_top (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .result(result), .cout(cout)
  );

  function automatic logic [W:0] ref_model(input logic [3:0] o,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
    logic [W:0] t;
    case (o)
      4'd0:  t = {1'b0, x & y};
      4'd1:  t = {1'b0, ~(x & y)};
      4'd2:  t = {1'b0, x | y};
      4'd3:  t = {1'b0, ~(x | y)};
      4'd4:  t = {1'b0, x};
      4'd5:  t = {1'b0, x ^ y};
      4'd6:  t = {1'b0, y};
      4'd7:  t = {1'b0, ~(x ^ y)};
      4'd8:  t = {1'b0, x} + {1'b0, y};
      4'd9:  t = {1'b0, x} + 1;
      4'd10: t = {1'b0, ~x} + 1;
      4'd11: t = {1'b0, {W{1'b1}}};
      4'd12: t = {(x < y), x - y};
      4'd13: t = {(x == '0), x - 1'b1};
      4'd14: t = {1'b0, ~x};
      default: t = '0;
    endcase
    return t;
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0, 4'd1, 4'd2, 4'd3:  return "R3";
      4'd4, 4'd5, 4'd6, 4'd7:  return "R4";
      4'd8:                    return "R5";
      4'd9, 4'd10:             return "R6";
      4'd12:                   return "R8";
      4'd13:                   return "R9";
      default:                 return "R7";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y);
    logic [W:0] exp;
    @(negedge clk);
    op = o; a = x; b = y;
    exp = ref_model(o, x, y);
    @(negedge clk);
    checks++;
    if ({cout, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: got cout=%b result=%h, expected cout=%b result=%h",
               tag(o), o, x, y, cout, result, exp[W], exp[W-1:0]);
    end
    if (o[3] == 1'b0) begin
      checks++;
      if (cout !== 1'b0) begin
        errors++;
        $display("FAIL R2 op=%0d: got cout=%b expected 0", o, cout);
      end
    end
  endtask

  initial begin : watchdog
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] corners [3];
    void'($urandom(32'd1234));
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = 32'h8000_0000;

    // R1: reset clears outputs
    op = 4'd11; a = '1; b = '1;
    repeat (2) @(negedge clk);
    checks++;
    if (result !== '0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got result=%h cout=%b expected 0/0", result, cout);
    end
    rst = 1'b0;

    // directed ripple corners (R6, R8, R9)
    apply(4'd9,  '1, '0);
    apply(4'd10, '0, '0);
    apply(4'd8,  '1, 32'd1);
    apply(4'd12, '0, 32'd1);
    apply(4'd13, '0, '0);
    apply(4'd13, 32'h8000_0000, '0);

    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          apply(4'(o), corners[i], corners[j]);
      for (int k = 0; k < 40; k++)
        apply(4'(o), $urandom, $urandom);
    end

    // R1: reset mid-run clears registered outputs
    @(negedge clk);
    op = 4'd11; rst = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== '0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset mid-run: got result=%h cout=%b expected 0/0", result, cout);
    end
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule